// File: doc/BRIEF.md
# Multi-Channel Coincidence Trigger Controller

This block decides when a waveform event has happened on a bank of sampled channels. Each channel brings two discriminator bits, a low-level one and a high-level one. A separate external trigger line comes in beside them. The block finds rising edges on every one of these inputs. Each edge arms its input for a programmable window of clock cycles. A four-bit mode code selects one of eleven coincidence conditions, which are evaluated against the armed set every cycle.

When the selected condition is met, the block does three things in a single clock edge. It freezes sampling, latches which channels were armed, and raises a readout-request interrupt for the host side. While the interrupt is up, the block ignores all further discriminator activity. It re-arms only after the host returns an acknowledge, and at that point the latched pattern is cleared. The decision is registered once, so the stop reaches the sample memories one clock after the hit that completes the condition. At 200 MHz that is far inside a 250 ns budget.

Top module: `trig_coinc_ctrl`

## Requirements
- R1: After reset, `irq_o` and `freeze_o` are low, and `hit_pattern_o` and `mode_latched_o` are zero.
- R2: Only a rising edge (input high in a cycle after it was low) arms an input. The input stays armed in that cycle and for `win_len_i` further cycles. Two hits coincide exactly when their rising-edge cycles are at most `win_len_i` apart. A level held high arms only once.
- R3: Modes that use the external trigger have these codes: 0 fires on the external trigger alone; 3 on the external trigger with any low bit; 4 on the external trigger with any high bit; 10 on the external trigger with low bits on at least two different channels.
- R4: `irq_o` and `freeze_o` rise on the clock edge that ends the cycle in which the condition becomes true, which is one cycle of latency.
- R5: On that same edge, `hit_pattern_o[i]` takes 1 for every channel i whose low or high input is armed, and `mode_latched_o` takes the current mode code.
- R6: While `irq_o` is high and no acknowledge is given, new hits and mode changes have no effect. `irq_o` stays high and the pattern and latched mode hold. Hits that arrive in this period are not remembered after re-arming.
- R7: An `irq_ack_i` high while `irq_o` is high clears `irq_o`, `freeze_o` and `hit_pattern_o` on the next edge, and the block re-arms.
- R8: Mode 5 fires on a second rising edge of the same channel's low bit while that channel is still armed, meaning within `win_len_i` cycles of the first edge. Mode 8 needs that same double pulse with the external trigger armed.
- R9: Channel-only modes have these codes: 1 fires on any low bit; 2 on any high bit; 6 on low bits of at least two different channels; 7 on low and high bits of the same channel; 9 on low bits of both channels of a pair (2k, 2k+1).
- R10: Mode codes 11 to 15 never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_lo_i | input | N_CH | Low-level discriminator bit per channel |
| hit_hi_i | input | N_CH | High-level discriminator bit per channel |
| ext_trig_i | input | 1 | External trigger |
| mode_i | input | MODE_W | Coincidence mode code |
| win_len_i | input | WIN_W | Extra cycles an input stays armed after its edge |
| irq_ack_i | input | 1 | Host acknowledge, re-arms the block |
| irq_o | output | 1 | Readout-request interrupt |
| freeze_o | output | 1 | Stop sampling in the memories |
| hit_pattern_o | output | N_CH | Channels armed when the trigger fired |
| mode_latched_o | output | MODE_W | Mode code in force when the trigger fired |

## Verification
The bench builds the block with sixteen channels and a six-bit window field, and runs it with a window of four cycles. This keeps both sides of the window boundary within a few cycles. Edges exactly four cycles apart must fire, and edges five apart must not. All sixteen channels stay present, so the pair mode can be checked on both an aligned pair (6, 7) and a straddling pair (7, 8). The two-distinct-channel modes can also be told apart from a double pulse on one channel.

// File: rtl/trig_coinc_pkg.sv
package trig_coinc_pkg;

  typedef enum logic [3:0] {
    MODE_EXT_ONLY   = 4'd0,
    MODE_ANY_LO     = 4'd1,
    MODE_ANY_HI     = 4'd2,
    MODE_EXT_LO     = 4'd3,
    MODE_EXT_HI     = 4'd4,
    MODE_DOUBLE     = 4'd5,
    MODE_TWO_CH     = 4'd6,
    MODE_LO_HI      = 4'd7,
    MODE_EXT_DOUBLE = 4'd8,
    MODE_PAIR       = 4'd9,
    MODE_EXT_TWO    = 4'd10
  } coinc_mode_e;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_FIRED = 1'b1
  } ctrl_state_e;

endpackage

// File: rtl/trig_edge_arm.sv
module trig_edge_arm #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             hold_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             rise_o,
  output logic             armed_o,
  output logic             again_o
);

  logic             prev_q;
  logic [WIN_W-1:0] cnt_q;
  logic             cnt_live;

  assign cnt_live = (cnt_q != '0);
  assign rise_o   = hit_i & ~prev_q & ~hold_i;
  assign armed_o  = rise_o | cnt_live;
  assign again_o  = rise_o & cnt_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= hit_i;
      if (hold_i)        cnt_q <= '0;
      else if (rise_o)   cnt_q <= win_len_i;
      else if (cnt_live) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_RISE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> (cnt_q == $past(win_len_i)));  // R2
  AST_HOLD_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));  // R6

endmodule

// File: rtl/trig_mode_eval.sv
module trig_mode_eval
  import trig_coinc_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   armed_lo_i,
  input  logic [N_CH-1:0]   armed_hi_i,
  input  logic [N_CH-1:0]   again_lo_i,
  input  logic              ext_armed_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              fire_o,
  output logic [N_CH-1:0]   hit_vec_o
);

  localparam int N_PAIR = N_CH / 2;

  function automatic int count_set(input logic [N_CH-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < N_CH; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic pair_hit(input logic [N_CH-1:0] v);
    logic r;
    r = 1'b0;
    for (int k = 0; k < N_PAIR; k++) r |= v[2*k] & v[2*k+1];
    return r;
  endfunction

  logic any_lo, any_hi, two_lo, lo_hi_same, pair_lo, dbl_lo;

  assign any_lo     = |armed_lo_i;
  assign any_hi     = |armed_hi_i;
  assign two_lo     = (count_set(armed_lo_i) >= 2);
  assign lo_hi_same = |(armed_lo_i & armed_hi_i);
  assign pair_lo    = pair_hit(armed_lo_i);
  assign dbl_lo     = |again_lo_i;
  assign hit_vec_o  = armed_lo_i | armed_hi_i;

  always_comb begin
    case (mode_i)
      MODE_EXT_ONLY:   fire_o = ext_armed_i;
      MODE_ANY_LO:     fire_o = any_lo;
      MODE_ANY_HI:     fire_o = any_hi;
      MODE_EXT_LO:     fire_o = ext_armed_i & any_lo;
      MODE_EXT_HI:     fire_o = ext_armed_i & any_hi;
      MODE_DOUBLE:     fire_o = dbl_lo;
      MODE_TWO_CH:     fire_o = two_lo;
      MODE_LO_HI:      fire_o = lo_hi_same;
      MODE_EXT_DOUBLE: fire_o = ext_armed_i & dbl_lo;
      MODE_PAIR:       fire_o = pair_lo;
      MODE_EXT_TWO:    fire_o = ext_armed_i & two_lo;
      default:         fire_o = 1'b0;
    endcase
  end

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > MODE_W'(10)) |-> !fire_o);  // R10
  AST_FIRE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (ext_armed_i || (hit_vec_o != '0)));  // R5

endmodule

// File: rtl/trig_fire_ctrl.sv
module trig_fire_ctrl
  import trig_coinc_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [N_CH-1:0]   hit_vec_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ack_i,
  output logic              fired_o,
  output logic [N_CH-1:0]   pattern_o,
  output logic [MODE_W-1:0] mode_latched_o
);

  ctrl_state_e state_q;
  logic        take_fire;
  logic        take_ack;

  assign take_fire = (state_q == ST_ARMED) & fire_i;
  assign take_ack  = (state_q == ST_FIRED) & ack_i;
  assign fired_o   = (state_q == ST_FIRED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_ARMED;
      pattern_o      <= '0;
      mode_latched_o <= '0;
    end else if (take_fire) begin
      state_q        <= ST_FIRED;
      pattern_o      <= hit_vec_i;
      mode_latched_o <= mode_i;
    end else if (take_ack) begin
      state_q        <= ST_ARMED;
      pattern_o      <= '0;
    end
  end

  AST_FIRE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> fired_o);  // R4
  AST_LATCH_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> (pattern_o == $past(hit_vec_i)) && (mode_latched_o == $past(mode_i)));  // R5
  AST_HOLD_WHILE_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_o && !ack_i) |=> fired_o && $stable(pattern_o) && $stable(mode_latched_o));  // R6
  AST_ACK_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_o && ack_i) |=> !fired_o && (pattern_o == '0));  // R7

endmodule

// File: rtl/trig_coinc_ctrl.sv
module trig_coinc_ctrl
  import trig_coinc_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int WIN_W  = 8,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   hit_lo_i,
  input  logic [N_CH-1:0]   hit_hi_i,
  input  logic              ext_trig_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic              freeze_o,
  output logic [N_CH-1:0]   hit_pattern_o,
  output logic [MODE_W-1:0] mode_latched_o
);

  logic [N_CH-1:0] rise_lo, rise_hi;
  logic [N_CH-1:0] armed_lo, armed_hi;
  logic [N_CH-1:0] again_lo, again_hi;
  logic            ext_rise, ext_armed, ext_again;
  logic            hold;
  logic            fire_now;
  logic [N_CH-1:0] hit_vec;
  logic            fired;

  assign hold = fired;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    trig_edge_arm #(.WIN_W(WIN_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_lo_i[c]), .hold_i(hold),
      .win_len_i(win_len_i), .rise_o(rise_lo[c]), .armed_o(armed_lo[c]),
      .again_o(again_lo[c]));
    trig_edge_arm #(.WIN_W(WIN_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_hi_i[c]), .hold_i(hold),
      .win_len_i(win_len_i), .rise_o(rise_hi[c]), .armed_o(armed_hi[c]),
      .again_o(again_hi[c]));
  end

  trig_edge_arm #(.WIN_W(WIN_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .hit_i(ext_trig_i), .hold_i(hold),
    .win_len_i(win_len_i), .rise_o(ext_rise), .armed_o(ext_armed),
    .again_o(ext_again));

  trig_mode_eval #(.N_CH(N_CH), .MODE_W(MODE_W)) u_eval (
    .clk(clk), .rst_n(rst_n),
    .armed_lo_i(armed_lo), .armed_hi_i(armed_hi), .again_lo_i(again_lo),
    .ext_armed_i(ext_armed), .mode_i(mode_i),
    .fire_o(fire_now), .hit_vec_o(hit_vec));

  trig_fire_ctrl #(.N_CH(N_CH), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_now), .hit_vec_i(hit_vec),
    .mode_i(mode_i), .ack_i(irq_ack_i), .fired_o(fired),
    .pattern_o(hit_pattern_o), .mode_latched_o(mode_latched_o));

  assign irq_o    = fired;
  assign freeze_o = fired;

  AST_NO_EDGE_WHILE_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rise_lo == '0) && (rise_hi == '0) && !ext_rise);  // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !irq_o && (hit_pattern_o == '0));  // R1
  AST_HELD_LEVEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig_i && $past(ext_trig_i)) |-> !ext_rise);  // R2
  AST_AGAIN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_again || (again_hi != '0)) |-> (ext_armed || (armed_hi != '0)));  // R8

endmodule

// File: tb/trig_coinc_ctrl_tb_top.sv
module trig_coinc_ctrl_tb_top;

  localparam int N_CH   = 16;
  localparam int WIN_W  = 6;
  localparam int MODE_W = 4;
  localparam int WIN    = 4;

  localparam int K_EXT = 0;
  localparam int K_LO  = 1;
  localparam int K_HI  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_CH-1:0]   hit_lo = '0;
  logic [N_CH-1:0]   hit_hi = '0;
  logic              ext_trig = 1'b0;
  logic [MODE_W-1:0] mode = '0;
  logic [WIN_W-1:0]  win_len = WIN_W'(WIN);
  logic              irq_ack = 1'b0;
  logic              irq, freeze;
  logic [N_CH-1:0]   pattern;
  logic [MODE_W-1:0] mode_lat;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  trig_coinc_ctrl #(.N_CH(N_CH), .WIN_W(WIN_W), .MODE_W(MODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_lo_i(hit_lo), .hit_hi_i(hit_hi),
    .ext_trig_i(ext_trig), .mode_i(mode), .win_len_i(win_len),
    .irq_ack_i(irq_ack), .irq_o(irq), .freeze_o(freeze),
    .hit_pattern_o(pattern), .mode_latched_o(mode_lat));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int kind, input int ch, input logic v);
    case (kind)
      K_EXT:   ext_trig = v;
      K_LO:    hit_lo[ch] = v;
      default: hit_hi[ch] = v;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Fired state: hits ignored, mode change ignored, ack clears, nothing carries over
  task automatic ignore_and_ack(input string req, input logic [N_CH-1:0] exp_pat,
                                input logic [MODE_W-1:0] exp_mode);
    mode = MODE_W'(1);
    @(negedge clk); hit_lo[0] = 1'b1; ext_trig = 1'b1;
    @(negedge clk); hit_lo[0] = 1'b0; ext_trig = 1'b0;
    @(negedge clk);
    check("R6", {req, " irq held"}, irq, 1);
    check("R6", {req, " pattern held"}, pattern, exp_pat);
    check("R6", {req, " mode held"}, mode_lat, exp_mode);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R7", {req, " irq cleared"}, irq, 0);
    check("R7", {req, " freeze cleared"}, freeze, 0);
    check("R7", {req, " pattern cleared"}, pattern, 0);
    idle(WIN + 2);
    check("R6", {req, " no carry-over"}, irq, 0);
  endtask

  task automatic run_case(input string req, input int m,
                          input int ka, input int ca, input int kb, input int cb,
                          input int gap, input bit exp_fire, input logic [N_CH-1:0] exp_pat);
    mode = MODE_W'(m);
    @(negedge clk);
    drive(ka, ca, 1'b1);
    if (gap == 0) drive(kb, cb, 1'b1);
    for (int j = 1; j <= gap; j++) begin
      @(negedge clk);
      if (j == 1) drive(ka, ca, 1'b0);
      if (j == gap) drive(kb, cb, 1'b1);
    end
    @(negedge clk);
    drive(ka, ca, 1'b0);
    drive(kb, cb, 1'b0);
    check(req, $sformatf("mode %0d gap %0d irq", m, gap), irq, exp_fire);
    check("R4", $sformatf("mode %0d freeze", m), freeze, exp_fire);
    if (exp_fire) begin
      check("R5", $sformatf("mode %0d pattern", m), pattern, exp_pat);
      check("R5", $sformatf("mode %0d mode latched", m), mode_lat, m);
      ignore_and_ack(req, exp_pat, MODE_W'(m));
    end else begin
      idle(WIN + 2);
      check(req, $sformatf("mode %0d stays quiet", m), irq, 0);
    end
  endtask

  // R2: a held level arms only once, so no double pulse
  task automatic held_level;
    mode = MODE_W'(5);
    @(negedge clk); hit_lo[4] = 1'b1;
    idle(WIN + 3);
    check("R2", "held level no double", irq, 0);
    hit_lo[4] = 1'b0;
    idle(WIN + 2);
  endtask

  initial begin
    idle(3);
    check("R1", "irq at reset", irq, 0);
    check("R1", "freeze at reset", freeze, 0);
    check("R1", "pattern at reset", pattern, 0);
    check("R1", "mode latched at reset", mode_lat, 0);
    rst_n = 1'b1;
    idle(2);

    run_case("R3", 0, K_EXT, 0, K_EXT, 0, 0, 1'b1, 16'h0000);
    run_case("R3", 3, K_EXT, 0, K_LO, 5, 3, 1'b1, 16'h0020);
    run_case("R2", 3, K_EXT, 0, K_LO, 5, WIN, 1'b1, 16'h0020);
    run_case("R2", 3, K_EXT, 0, K_LO, 5, WIN + 1, 1'b0, 16'h0000);
    run_case("R2", 3, K_LO, 11, K_EXT, 0, WIN, 1'b1, 16'h0800);
    run_case("R3", 4, K_EXT, 0, K_HI, 10, 1, 1'b1, 16'h0400);
    run_case("R3", 4, K_EXT, 0, K_LO, 10, 1, 1'b0, 16'h0000);
    run_case("R8", 5, K_LO, 3, K_LO, 3, 2, 1'b1, 16'h0008);
    run_case("R8", 5, K_LO, 3, K_LO, 3, WIN, 1'b1, 16'h0008);
    run_case("R8", 5, K_LO, 3, K_LO, 3, WIN + 1, 1'b0, 16'h0000);
    run_case("R9", 6, K_LO, 1, K_LO, 9, 2, 1'b1, 16'h0202);
    run_case("R9", 6, K_LO, 1, K_LO, 1, 2, 1'b0, 16'h0000);
    run_case("R9", 7, K_LO, 2, K_HI, 2, 1, 1'b1, 16'h0004);
    run_case("R9", 7, K_LO, 2, K_HI, 3, 1, 1'b0, 16'h0000);
    run_case("R9", 9, K_LO, 6, K_LO, 7, 1, 1'b1, 16'h00C0);
    run_case("R9", 9, K_LO, 7, K_LO, 8, 1, 1'b0, 16'h0000);
    run_case("R9", 1, K_LO, 15, K_LO, 15, 0, 1'b1, 16'h8000);
    run_case("R9", 2, K_HI, 12, K_HI, 12, 0, 1'b1, 16'h1000);
    run_case("R3", 10, K_LO, 0, K_LO, 14, 0, 1'b0, 16'h0000);
    run_case("R3", 10, K_LO, 0, K_EXT, 0, 0, 1'b0, 16'h0000);
    // mode 10: two channels plus external trigger
    mode = MODE_W'(10);
    @(negedge clk); hit_lo[0] = 1'b1; hit_lo[14] = 1'b1;
    @(negedge clk); hit_lo[0] = 1'b0; hit_lo[14] = 1'b0; ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    check("R3", "mode 10 three-way irq", irq, 1);
    check("R5", "mode 10 pattern", pattern, 16'h4001);
    ignore_and_ack("R3", 16'h4001, MODE_W'(10));
    // mode 8: external trigger plus double pulse
    mode = MODE_W'(8);
    @(negedge clk); ext_trig = 1'b1; hit_lo[13] = 1'b1;
    @(negedge clk); ext_trig = 1'b0; hit_lo[13] = 1'b0;
    @(negedge clk); hit_lo[13] = 1'b1;
    @(negedge clk); hit_lo[13] = 1'b0;
    check("R8", "mode 8 irq", irq, 1);
    check("R5", "mode 8 pattern", pattern, 16'h2000);
    ignore_and_ack("R8", 16'h2000, MODE_W'(8));
    run_case("R8", 8, K_LO, 13, K_LO, 13, 2, 1'b0, 16'h0000);
    run_case("R10", 12, K_EXT, 0, K_LO, 4, 0, 1'b0, 16'h0000);
    run_case("R10", 15, K_LO, 6, K_LO, 7, 1, 1'b0, 16'h0000);
    held_level();
    // R7: ack while armed is ignored
    mode = MODE_W'(1);
    irq_ack = 1'b1;
    @(negedge clk); hit_lo[9] = 1'b1;
    @(negedge clk); hit_lo[9] = 1'b0; irq_ack = 1'b0;
    check("R7", "ack while armed ignored", irq, 1);
    check("R5", "ack while armed pattern", pattern, 16'h0200);
    ignore_and_ack("R7", 16'h0200, MODE_W'(1));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule